// File: doc/BRIEF.md
# Switching Regulator Sleep Controller

This block decides whether each of four switching regulators stays powered while the device sleeps. It also decides which output-voltage code each regulator returns to when the device wakes. One 8-bit configuration register sits on a simple register bus. It holds an off-in-sleep request per regulator, a spare bit and a wake-voltage selector. A separate keep-on mask, one bit per regulator, comes in as a plain input and overrides any off request. The device state is tracked from two single-cycle strobes, one for entering sleep and one for leaving it.

Each regulator has a working voltage code that the host writes through a per-regulator write strobe. When sleep is entered, every working code is copied into a shadow register. When the device wakes, each regulator that was off reloads its working code in that same clock cycle. The new value is either the reset-default code or the shadowed code, chosen by the selector bit. Regulators that stayed on during sleep keep their working code. All pins are plain control and status pins. Nothing flows as a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `smps_sleep_ctrl`

## Requirements
- R1: After reset, the configuration register reads 0x00, all four enables are 1, and every voltage code equals its reset-default code (regulator 0: 33, regulator 1: 24, regulator 2: 18, regulator 3: 45).
- R2: A bus write at offset 0x44 stores the data, which is visible on the read port from the next cycle. Bits 6:5 always read 0. Bit 4 is a spare that reads back what was written.
- R3: Writes at any offset other than 0x44 leave the register unchanged. Reads at any other offset return 0x00 in the same cycle.
- R4: While the device is ACTIVE, every enable is 1, whatever the off-request bits hold.
- R5: While the device is in SLEEP, regulator i (bit i of the register: bit 0 is the I/O regulator, bits 1 to 3 are regulators 1 to 3) has enable 0 exactly when its off-request bit is 1 and keep-on bit i is 0. Enables change one edge after the sleep strobe is sampled. A keep-on change acts within the same cycle.
- R6: On the ACTIVE-to-SLEEP strobe each working code is copied to its shadow. On the SLEEP-to-ACTIVE strobe, when bit 7 is 1, each regulator whose enable is 0 at that edge reloads its reset-default code.
- R7: On the SLEEP-to-ACTIVE strobe with bit 7 at 0, each regulator whose enable is 0 reloads the code it held when sleep was entered.
- R8: A regulator that stays enabled through sleep keeps its working code across the wake strobe. The spare bit never changes an enable or a code.
- R9: A code write strobe for regulator i loads the write data into its working code, visible from the next cycle. A wake reload at the same edge takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register bus offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| keep_on | input | 4 | Per-regulator keep-on mask, bit i for regulator i |
| go_sleep | input | 1 | ACTIVE-to-SLEEP strobe |
| go_active | input | 1 | SLEEP-to-ACTIVE strobe |
| code_wr | input | 4 | Per-regulator voltage code write strobes |
| code_wdata | input | 6 | Voltage code write data |
| reg_en | output | 4 | Regulator enables |
| reg_code | output | 24 | Voltage codes, regulator i at bits [6i+5:6i] |

## Verification
Read data and the effect of keep-on changes are combinational, so they are due in the cycle the stimulus is applied. Register writes, code writes, the sleep state and the wake reload each pass through one register, so they are due one edge later. The driver applies each cycle's inputs shortly after a rising edge. It predicts the outputs for that same cycle from its own model of the register, sleep flag, working codes and shadows, then queues the prediction with that cycle number. The monitor compares at the falling edge, so every registered result is checked in the cycle after its cause.

// File: rtl/smps_sleep_pkg.sv
package smps_sleep_pkg;
  localparam int NUM_REG = 4;
  localparam int CFG_W = 8;
  localparam logic [7:0] CFG_OFFSET = 8'h44;
  localparam logic [CFG_W-1:0] CFG_WMASK = 8'h9F;
  localparam int DEFSEL_BIT = 7;

  typedef enum logic {
    ST_ACTIVE = 1'b0,
    ST_SLEEP  = 1'b1
  } dev_state_e;
endpackage

// File: rtl/smps_cfg_reg.sv
module smps_cfg_reg
  import smps_sleep_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CFG_W-1:0]  bus_wdata,
  output logic [CFG_W-1:0]  bus_rdata,
  output logic [NUM_REG-1:0] off_req,
  output logic              def_sel
);
  logic [CFG_W-1:0] cfg_q;
  logic             hit;

  assign hit = (bus_addr == ADDR_W'(CFG_OFFSET));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (bus_wr && hit) cfg_q <= bus_wdata & CFG_WMASK;
  end

  assign bus_rdata = hit ? cfg_q : '0;
  assign off_req   = cfg_q[NUM_REG-1:0];
  assign def_sel   = cfg_q[DEFSEL_BIT];

  assert_other_offset_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit) |=> $stable(cfg_q));
  assert_rsvd_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (bus_rdata[6:5] == 2'b00));
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit) |=> (cfg_q[3:0] == $past(bus_wdata[3:0])));
endmodule

// File: rtl/smps_state_track.sv
module smps_state_track
  import smps_sleep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_sleep,
  input  logic go_active,
  output logic in_sleep,
  output logic sleep_entry,
  output logic sleep_exit
);
  dev_state_e state_q;

  assign sleep_entry = go_sleep && (state_q == ST_ACTIVE);
  assign sleep_exit  = go_active && (state_q == ST_SLEEP);
  assign in_sleep    = (state_q == ST_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ACTIVE;
    else if (sleep_entry) state_q <= ST_SLEEP;
    else if (sleep_exit) state_q <= ST_ACTIVE;
  end

  assert_entry_sets_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_entry |=> in_sleep);
  assert_exit_clears_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_exit |=> !in_sleep);
endmodule

// File: rtl/smps_volt_slot.sv
module smps_volt_slot #(
  parameter int VW = 6,
  parameter logic [VW-1:0] DEF_CODE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_entry,
  input  logic          sleep_exit,
  input  logic          off_now,
  input  logic          use_def,
  input  logic          code_wr,
  input  logic [VW-1:0] code_wdata,
  output logic [VW-1:0] code_out
);
  logic [VW-1:0] work_q;
  logic [VW-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q   <= DEF_CODE;
      shadow_q <= DEF_CODE;
    end else begin
      if (sleep_entry) shadow_q <= work_q;
      if (sleep_exit && off_now) work_q <= use_def ? DEF_CODE : shadow_q;
      else if (code_wr) work_q <= code_wdata;
    end
  end

  assign code_out = work_q;

  assert_shadow_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_entry |=> (shadow_q == $past(work_q)));
  assert_wake_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_exit && off_now && use_def) |=> (code_out == DEF_CODE));
  assert_wake_shadow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_exit && off_now && !use_def) |=> (code_out == $past(shadow_q)));
  assert_stay_on_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_exit && !off_now && !code_wr) |=> $stable(code_out));
  assert_code_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (code_wr && !sleep_exit) |=> (code_out == $past(code_wdata)));
endmodule

// File: rtl/smps_sleep_ctrl.sv
module smps_sleep_ctrl
  import smps_sleep_pkg::*;
#(
  parameter int VW = 6,
  parameter logic [NUM_REG*VW-1:0] DEF_CODES = {6'd45, 6'd18, 6'd24, 6'd33}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            bus_addr,
  input  logic                  bus_wr,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  input  logic [NUM_REG-1:0]    keep_on,
  input  logic                  go_sleep,
  input  logic                  go_active,
  input  logic [NUM_REG-1:0]    code_wr,
  input  logic [VW-1:0]         code_wdata,
  output logic [NUM_REG-1:0]    reg_en,
  output logic [NUM_REG*VW-1:0] reg_code
);
  logic [NUM_REG-1:0] off_req;
  logic               def_sel;
  logic               in_sleep;
  logic               sleep_entry;
  logic               sleep_exit;

  smps_cfg_reg #(.ADDR_W(8)) u_cfg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .off_req(off_req), .def_sel(def_sel)
  );

  smps_state_track u_state (
    .clk(clk), .rst_n(rst_n), .go_sleep(go_sleep), .go_active(go_active),
    .in_sleep(in_sleep), .sleep_entry(sleep_entry), .sleep_exit(sleep_exit)
  );

  for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
    assign reg_en[i] = !(in_sleep && off_req[i] && !keep_on[i]);

    smps_volt_slot #(.VW(VW), .DEF_CODE(DEF_CODES[i*VW +: VW])) u_slot (
      .clk(clk), .rst_n(rst_n), .sleep_entry(sleep_entry), .sleep_exit(sleep_exit),
      .off_now(!reg_en[i]), .use_def(def_sel), .code_wr(code_wr[i]),
      .code_wdata(code_wdata), .code_out(reg_code[i*VW +: VW])
    );

    assert_keep_on_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sleep && keep_on[i]) |-> reg_en[i]);
  end

  assert_active_all_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sleep |-> (&reg_en));
endmodule

// File: tb/smps_sleep_ctrl_bench.sv
module smps_sleep_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h44;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [3:0] keep_on = 4'h0;
  logic go_sleep = 1'b0;
  logic go_active = 1'b0;
  logic [3:0] code_wr = 4'h0;
  logic [5:0] code_wdata = 6'd0;
  logic [3:0] reg_en;
  logic [23:0] reg_code;

  smps_sleep_ctrl u_smps_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .keep_on(keep_on),
    .go_sleep(go_sleep), .go_active(go_active), .code_wr(code_wr),
    .code_wdata(code_wdata), .reg_en(reg_en), .reg_code(reg_code)
  );

  always #5 clk = ~clk;

  typedef struct {
    string req;
    logic [3:0] en;
    logic [7:0] rd;
    logic [23:0] code;
    int due;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // pending stimulus for the next step
  logic [7:0] p_addr = 8'h44;
  logic p_wr = 1'b0;
  logic [7:0] p_wdata = 8'h00;
  logic [3:0] p_keep = 4'h0;
  logic p_gs = 1'b0;
  logic p_ga = 1'b0;
  logic [3:0] p_vwr = 4'h0;
  logic [5:0] p_vdata = 6'd0;

  // reference model
  logic [7:0] m_cfg = 8'h00;
  logic m_sleep = 1'b0;
  logic [5:0] m_work [4];
  logic [5:0] m_shadow [4];

  function automatic logic [5:0] defc(input int i);
    case (i)
      0: return 6'd33;
      1: return 6'd24;
      2: return 6'd18;
      default: return 6'd45;
    endcase
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  task automatic step(input string req);
    exp_t it;
    logic [3:0] en_now;
    logic gs_acc, ga_acc;
    @(posedge clk);
    #2;
    bus_addr = p_addr; bus_wr = p_wr; bus_wdata = p_wdata; keep_on = p_keep;
    go_sleep = p_gs; go_active = p_ga; code_wr = p_vwr; code_wdata = p_vdata;
    for (int i = 0; i < 4; i++) en_now[i] = !(m_sleep && m_cfg[i] && !p_keep[i]);
    it.req = req;
    it.en = en_now;
    it.rd = (p_addr == 8'h44) ? m_cfg : 8'h00;
    it.code = {m_work[3], m_work[2], m_work[1], m_work[0]};
    it.due = cyc;
    exp_q.push_back(it);
    gs_acc = p_gs && !m_sleep;
    ga_acc = p_ga && m_sleep;
    for (int i = 0; i < 4; i++) begin
      if (gs_acc) m_shadow[i] = m_work[i];
      if (ga_acc && !en_now[i]) m_work[i] = m_cfg[7] ? defc(i) : m_shadow[i];
      else if (p_vwr[i]) m_work[i] = p_vdata;
    end
    if (p_wr && p_addr == 8'h44) m_cfg = p_wdata & 8'h9F;
    if (gs_acc) m_sleep = 1'b1;
    if (ga_acc) m_sleep = 1'b0;
    p_wr = 1'b0; p_gs = 1'b0; p_ga = 1'b0; p_vwr = 4'h0;
  endtask

  always @(negedge clk) begin
    exp_t it;
    while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      it = exp_q.pop_front();
      checks++;
      if (reg_en !== it.en) begin
        failures++;
        $display("FAIL %s enables: actual %b expected %b (cycle %0d)", it.req, reg_en, it.en, cyc);
      end
      checks++;
      if (bus_rdata !== it.rd) begin
        failures++;
        $display("FAIL %s read data: actual %h expected %h (cycle %0d)", it.req, bus_rdata, it.rd, cyc);
      end
      checks++;
      if (reg_code !== it.code) begin
        failures++;
        $display("FAIL %s codes: actual %h expected %h (cycle %0d)", it.req, reg_code, it.code, cyc);
      end
    end
  end

  task automatic wr_cfg(input logic [7:0] a, input logic [7:0] d, input string req);
    p_addr = a; p_wr = 1'b1; p_wdata = d;
    step(req);
    p_addr = 8'h44;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_work[i] = defc(i);
      m_shadow[i] = defc(i);
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    step("R1"); step("R1");
    // R2 write and read back, reserved bits masked, spare kept
    wr_cfg(8'h44, 8'hFF, "R2"); step("R2");
    // R3 other offsets
    wr_cfg(8'h45, 8'h00, "R3"); step("R3");
    p_addr = 8'h45; step("R3"); p_addr = 8'h43; step("R3"); p_addr = 8'h44;
    wr_cfg(8'h44, 8'h00, "R2"); step("R2");
    // R9 code writes
    p_vwr = 4'b0011; p_vdata = 6'd10; step("R9");
    p_vwr = 4'b1000; p_vdata = 6'd50; step("R9"); step("R9");
    // R4 active enables stay on despite off requests
    wr_cfg(8'h44, 8'h0F, "R4"); p_keep = 4'b0010; step("R4"); step("R4");
    // R5 sleep entry, keep-on override
    p_gs = 1'b1; step("R5"); step("R5");
    p_keep = 4'b0000; step("R5"); p_keep = 4'b0010; step("R5");
    // R9 writes during sleep
    p_vwr = 4'b0011; p_vdata = 6'd7; step("R9");
    p_vwr = 4'b0010; p_vdata = 6'd12; step("R9"); step("R9");
    // R7 wake with shadow codes, R8 kept-on regulator keeps its code
    p_ga = 1'b1; step("R7"); step("R7"); step("R8");
    // R6 wake with defaults; wake reload beats a same-cycle write
    wr_cfg(8'h44, 8'h9F, "R6");
    p_vwr = 4'b1111; p_vdata = 6'd5; step("R6");
    p_gs = 1'b1; step("R6"); step("R6");
    p_ga = 1'b1; p_vwr = 4'b0101; p_vdata = 6'd9; step("R9"); step("R6"); step("R8");
    // R8 spare bit alone has no effect in sleep
    wr_cfg(8'h44, 8'h10, "R8"); p_keep = 4'b0000; step("R8");
    p_gs = 1'b1; step("R8"); step("R8"); step("R8");
    p_ga = 1'b1; step("R8"); step("R8");
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule